// File: doc/BRIEF.md
# Next Program Address Generator

This block holds the program counter of a processor with a 32-bit instruction word and word-aligned instructions, and works out, in the same cycle, which address the next instruction comes from. It looks at the instruction being executed and at up to three register values: the pair compared by conditional branches, and the value used as the target of a register jump. The chosen address is loaded into the program counter on the next rising clock edge.

Four kinds of redirection are handled besides plain sequential advance. Conditional branches on equality or on inequality move by a signed word count measured from the address after the current instruction. Region jumps, with or without a link, take a 26-bit word index and keep the top four bits of the sequential address, so that they stay in the current 256 MB block. Register jumps take the whole target from a register value. A link address, always the sequential address, is offered on every cycle for the register file to store when it needs it.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low the program counter `pc_q` is 0; once released it changes only on rising edges of `clk`.
- R2: For any opcode (bits 31:26) other than 2, 3, 4 and 5, and for opcode 0 with any function field (bits 5:0) other than 8, `next_pc` is `pc_q`+4 and `taken` is 0.
- R3: Opcode 4 (branch-if-equal) with `rs_val` equal to `rt_val` gives `taken` 1 and `next_pc` = `pc_q`+4 + (sign-extended bits 15:0 shifted left by two).
- R4: Opcode 5 (branch-if-different) with `rs_val` unequal to `rt_val` gives `taken` 1 and the same target rule as R3.
- R5: A branch whose condition fails gives `next_pc` = `pc_q`+4 and `taken` 0.
- R6: A branch offset with bit 15 set moves backwards (offset 0xFFFC goes four words back from `pc_q`+4).
- R7: Opcode 2 (jump) gives `taken` 1 and `next_pc` = {bits 31:28 of `pc_q`+4, instruction bits 25:0, 2'b00}.
- R8: Opcode 3 (jump with link) gives the same target and `taken` as R7.
- R9: Opcode 0 with function field 8 (register jump) gives `taken` 1 and `next_pc` = `jreg_val`, independent of `rs_val`.
- R10: `link_pc` equals `pc_q`+4 for every instruction.
- R11: The upper four bits of a jump target come from `pc_q`+4, so a jump in the last word of a 256 MB block lands in the following block.
- R12: On each rising clock edge out of reset, `pc_q` takes the value `next_pc` had before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction currently executing |
| rs_val | input | 32 | First compared register value |
| rt_val | input | 32 | Second compared register value |
| jreg_val | input | 32 | Target value for a register jump |
| pc_q | output | 32 | Program counter register |
| next_pc | output | 32 | Address selected for the next instruction |
| link_pc | output | 32 | Return address, the sequential successor |
| taken | output | 1 | High when the flow is redirected |

## Verification
The instruction stream is a chain where each expected target becomes the next program counter, so a wrong target corrupts every later step. Each branch kind is tried with its condition both met and failed, which separates the equal and unequal tests and a swapped condition; forward and backward offsets separate sign extension from zero extension. A jump placed in the last word of a 256 MB block distinguishes upper bits taken from the sequential address from those of the current one, and a register jump with a differing `rs_val` shows the target source is the dedicated input.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      K_SEQ,
      K_BR_EQ,
      K_BR_NE,
      K_JUMP,
      K_JUMP_LINK,
      K_JUMP_REG
   } flow_kind_e;

   localparam int OPC_W = 6;
   localparam logic [OPC_W-1:0] OPC_REGOP = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JLINK = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BREQ  = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BRNE  = 6'd5;
   localparam logic [5:0]       FN_JREG   = 6'd8;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output flow_kind_e         kind
);
   localparam int FN_W = 6;

   logic [OPC_W-1:0] opc;
   logic [FN_W-1:0]  fn;

   assign opc = instr[INSTR_W-1 -: OPC_W];
   assign fn  = instr[FN_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_BREQ:  kind = K_BR_EQ;
         OPC_BRNE:  kind = K_BR_NE;
         OPC_JUMP:  kind = K_JUMP;
         OPC_JLINK: kind = K_JUMP_LINK;
         OPC_REGOP: kind = (fn == FN_JREG) ? K_JUMP_REG : K_SEQ;
         default:   kind = K_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int OFS_W   = 16,
   parameter int IDX_W   = 26
) (
   input  logic [ADDR_W-1:0]  pc,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  seq_addr,
   output logic [ADDR_W-1:0]  br_addr,
   output logic [ADDR_W-1:0]  jmp_addr
);
   localparam int REGION_W = ADDR_W - IDX_W - 2;
   localparam int SEXT_W   = ADDR_W - OFS_W - 2;

   generate
      if (SEXT_W < 0) begin : g_bad_ofs
         $error("npc_targets: offset field too wide for address");
      end
      if (REGION_W < 0) begin : g_bad_idx
         $error("npc_targets: jump index too wide for address");
      end
      if (IDX_W > INSTR_W || OFS_W > INSTR_W) begin : g_bad_instr
         $error("npc_targets: field wider than instruction");
      end
   endgenerate

   logic [OFS_W-1:0]  ofs;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] ofs_bytes;

   assign ofs       = instr[OFS_W-1:0];
   assign idx       = instr[IDX_W-1:0];
   assign seq_addr  = pc + ADDR_W'(4);

   generate
      if (SEXT_W > 0) begin : g_sext
         assign ofs_bytes = {{SEXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
      end else begin : g_nosext
         assign ofs_bytes = {ofs, 2'b00};
      end
   endgenerate

   assign br_addr = seq_addr + ofs_bytes;

   generate
      if (REGION_W > 0) begin : g_region
         assign jmp_addr = {seq_addr[ADDR_W-1 -: REGION_W], idx, 2'b00};
      end else begin : g_flat
         assign jmp_addr = {idx, 2'b00};
      end
   endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  flow_kind_e         kind,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   input  logic [ADDR_W-1:0]  seq_addr,
   input  logic [ADDR_W-1:0]  br_addr,
   input  logic [ADDR_W-1:0]  jmp_addr,
   input  logic [ADDR_W-1:0]  reg_addr,
   output logic [ADDR_W-1:0]  nxt,
   output logic               redirect
);
   logic same;
   assign same = (opa == opb);

   always_comb begin
      nxt      = seq_addr;
      redirect = 1'b0;
      unique case (kind)
         K_BR_EQ: if (same) begin
            nxt      = br_addr;
            redirect = 1'b1;
         end
         K_BR_NE: if (!same) begin
            nxt      = br_addr;
            redirect = 1'b1;
         end
         K_JUMP, K_JUMP_LINK: begin
            nxt      = jmp_addr;
            redirect = 1'b1;
         end
         K_JUMP_REG: begin
            nxt      = reg_addr;
            redirect = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
   import npc_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                OFS_W    = 16,
   parameter int                IDX_W    = 26,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] rs_val,
   input  logic [ADDR_W-1:0] rt_val,
   input  logic [ADDR_W-1:0] jreg_val,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] link_pc,
   output logic              taken
);
   localparam int INSTR_W = 32;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("nextpc_unit: address width too small");
      end
   endgenerate

   flow_kind_e        kind;
   logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr;

   npc_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .kind  (kind)
   );

   npc_targets #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
   ) u_tgt (
      .pc       (pc_q),
      .instr    (instr),
      .seq_addr (seq_addr),
      .br_addr  (br_addr),
      .jmp_addr (jmp_addr)
   );

   npc_select #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W)) u_sel (
      .kind     (kind),
      .opa      (rs_val),
      .opb      (rt_val),
      .seq_addr (seq_addr),
      .br_addr  (br_addr),
      .jmp_addr (jmp_addr),
      .reg_addr (jreg_val),
      .nxt      (next_pc),
      .redirect (taken)
   );

   assign link_pc = seq_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= next_pc;
   end

   // assertions
   logic [5:0] a_opc;
   assign a_opc = instr[31:26];

   p_reset_value_r1: assert property (@(posedge clk)
      !rst_n |=> pc_q == RESET_PC);

   p_pc_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> pc_q == $past(next_pc));

   p_idle_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> next_pc == link_pc);

   p_breq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_opc == OPC_BREQ && rs_val == rt_val) |-> taken);

   p_brne_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_opc == OPC_BRNE && rs_val == rt_val) |-> !taken);

   p_jreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_opc == OPC_REGOP && instr[5:0] == FN_JREG) |-> (taken && next_pc == jreg_val));

   p_region_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (a_opc == OPC_JUMP || a_opc == OPC_JLINK) |->
         (taken && next_pc[ADDR_W-1 -: 4] == link_pc[ADDR_W-1 -: 4] && next_pc[1:0] == 2'b00));
endmodule

// File: tb/nextpc_unit_test.sv
`timescale 1ns/1ps
module nextpc_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0, rs_val = '0, rt_val = '0, jreg_val = '0;
   logic [31:0] pc_q, next_pc, link_pc;
   logic        taken;

   int checks = 0;
   int bad = 0;

   always #5 clk = ~clk;

   nextpc_unit uut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
      .jreg_val(jreg_val), .pc_q(pc_q), .next_pc(next_pc), .link_pc(link_pc), .taken(taken)
   );

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] jv;
      logic [31:0] nxt;
      logic        tk;
      logic [7:0]  req;
   } vec_t;

   // req holds the requirement number for the message only
   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_0000, 32'h1, 32'h2, 32'h0, 32'h0000_0004, 1'b0, 8'd2},  // R2 pc=0
      '{32'h1000_0003, 32'h5, 32'h5, 32'h0, 32'h0000_0014, 1'b1, 8'd3},  // R3 pc=4
      '{32'h1000_0003, 32'h5, 32'h6, 32'h0, 32'h0000_0018, 1'b0, 8'd5},  // R5 pc=14
      '{32'h1400_0002, 32'h1, 32'h2, 32'h0, 32'h0000_0024, 1'b1, 8'd4},  // R4 pc=18
      '{32'h1400_0002, 32'h7, 32'h7, 32'h0, 32'h0000_0028, 1'b0, 8'd5},  // R5 pc=24
      '{32'h1000_FFFC, 32'h0, 32'h0, 32'h0, 32'h0000_001C, 1'b1, 8'd6},  // R6 pc=28
      '{32'h0800_0100, 32'h3, 32'h3, 32'h0, 32'h0000_0400, 1'b1, 8'd7},  // R7 pc=1C
      '{32'h0C00_0040, 32'h0, 32'h9, 32'h0, 32'h0000_0100, 1'b1, 8'd8},  // R8 pc=400
      '{32'h0000_0008, 32'h44, 32'h0, 32'h0FFF_FFFC, 32'h0FFF_FFFC, 1'b1, 8'd9}, // R9 pc=100
      '{32'h0800_0010, 32'h0, 32'h0, 32'h0, 32'h1000_0040, 1'b1, 8'd11}, // R11 pc=0FFFFFFC
      '{32'h2000_0008, 32'h0, 32'h0, 32'h0, 32'h1000_0044, 1'b0, 8'd2},  // R2 pc=10000040
      '{32'h0000_0008, 32'h0, 32'h0, 32'h0, 32'h0000_0000, 1'b1, 8'd9}   // R9 pc=10000044
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic [31:0] exp_pc;
      // R1: held in reset with a jump presented, pc stays 0
      instr = 32'h0800_0100;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset", pc_q, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_pc = 32'h0;

      for (int i = 0; i < NV; i++) begin
         instr    = VEC[i].ins;
         rs_val   = VEC[i].a;
         rt_val   = VEC[i].b;
         jreg_val = VEC[i].jv;
         #1;
         chk($sformatf("R12 pc row%0d", i), pc_q, exp_pc);
         chk($sformatf("R%0d next row%0d", VEC[i].req, i), next_pc, VEC[i].nxt);
         chk($sformatf("R%0d taken row%0d", VEC[i].req, i), {31'b0, taken}, {31'b0, VEC[i].tk});
         chk($sformatf("R10 link row%0d", i), link_pc, exp_pc + 32'd4);
         @(negedge clk);
         exp_pc = VEC[i].nxt;
      end
      #1;
      chk("R12 final pc", pc_q, 32'h0);

      // R2: opcode 0 with a function field other than 8 advances
      instr = 32'h0000_0009;
      #1;
      chk("R2 fn9 next", next_pc, 32'h4);
      chk("R2 fn9 taken", {31'b0, taken}, 32'h0);

      // R1: pc only moves on the rising edge
      @(posedge clk);
      #1;
      chk("R1 edge load", pc_q, 32'h4);
      @(negedge clk);
      #1;
      chk("R1 stable at falling edge", pc_q, 32'h4);

      // R6: largest backward branch wraps below zero
      instr = 32'h1400_8000; rs_val = 32'h1; rt_val = 32'h2;
      #1;
      chk("R6 min offset", next_pc, 32'hFFFE_0008);

      // R1: reset mid-run returns pc to 0
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset", pc_q, 32'h0);
      @(posedge clk);
      #1;
      chk("R1 reset held", pc_q, 32'h0);

      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule